// File: doc/BRIEF.md
# PATA PIO Bus Cycle Generator

This block turns single host register requests into programmed-I/O bus cycles on a parallel ATA device interface. The host presents a request with a direction, a 3-bit register index, a choice between the command register group and the control register group, and a flag asking for a 16-bit transfer. The block then runs one complete bus cycle. It drives the two chip selects, the device address, the read or write strobe and the data bus. On a read it captures the returned data. It pulses a completion flag when the cycle is over.

Cycle timing comes from three run-time registers that hold setup, pulse and total cycle lengths in clock cycles. Their reset values are derived from the slowest PIO mode (70 ns setup, 290 ns active, 600 ns cycle), rounded up for the configured clock period.

The block adds one clock to the setup phase so that line ringing can settle. It lengthens the cycle when fewer than two recovery clocks would remain. It places chip select inside the cycle with one clock of margin on each side. Writes use exactly the read timing. A device that reports not ready stretches the strobe.

Top module: `pio_cycle_gen`

## Requirements
- R1: While reset is active and whenever no cycle is running, both chip selects and both strobes are high (inactive), `dev_oe` is low and `host_done` is low.
- R2: A request is accepted at a clock edge where `host_req` is high and the block is idle. Phase 0 is the clock after that edge. The strobe for the access (`dev_rd_n` for reads, `dev_wr_n` for writes) goes low at phase S+1, where S is the programmed setup, and stays low for P clocks, where P is the programmed pulse. A programmed pulse of 0 is treated as 1. The two strobes are never low together.
- R3: The cycle lasts C clocks, where C is the programmed cycle length. If C is less than (S+1)+P+2, the cycle lasts (S+1)+P+2 clocks instead. `host_done` is high for exactly one clock, the clock after the last phase.
- R4: Chip select is low from phase 1 through phase C-2. For a command-group access (`host_ctl`=0), `dev_cs0_n` is low and `dev_cs1_n` is high. For a control-group access (`host_ctl`=1), `dev_cs0_n` is high and `dev_cs1_n` is low. `dev_addr` carries the request index and is stable for the whole cycle.
- R5: A write uses the same setup, pulse, cycle and chip-select timing as a read. `dev_oe` is high exactly during the chip-select-low phases of a write and never during a read.
- R6: A 16-bit transfer happens only when `host_wide`=1, `host_ctl`=0 and `host_idx`=0. Every other access is 8-bit and uses bits [7:0] of the bus. On an 8-bit write, `dev_dout[15:8]` is 0. On an 8-bit read, `host_rdata[15:8]` is 0.
- R7: A read captures `dev_din` at the clock edge where the strobe is released, that is, the value present during the last strobe-low clock. The captured value is on `host_rdata` when `host_done` pulses and stays there until the next read captures.
- R8: Each clock in which a strobe is low and `dev_ready` is low freezes the cycle for one clock. The strobe phase and the total cycle both grow by one clock per not-ready clock.
- R9: A request raised while a cycle is running is ignored. It changes neither the running cycle nor anything that follows it.
- R10: A `cfg_wr` pulse loads `cfg_setup`, `cfg_pulse` and `cfg_cycle`. After reset these hold ceil(70/T), ceil(290/T) and ceil(600/T), where T is `CLK_PERIOD_NS`. A running cycle keeps the timing it started with, and new values apply from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load the three timing registers |
| cfg_setup | input | CNT_W | Setup length in clocks (before the ringing clock is added) |
| cfg_pulse | input | CNT_W | Strobe length in clocks |
| cfg_cycle | input | CNT_W | Total cycle length in clocks |
| host_req | input | 1 | Start an access (taken only when idle) |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_ctl | input | 1 | 1 = control register group, 0 = command group |
| host_wide | input | 1 | Request a 16-bit transfer |
| host_idx | input | 3 | Register index |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Captured read data |
| host_done | output | 1 | One-clock completion pulse |
| dev_cs0_n | output | 1 | Command-group chip select, active low |
| dev_cs1_n | output | 1 | Control-group chip select, active low |
| dev_addr | output | 3 | Device register address |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_dout | output | 16 | Data driven to the bus |
| dev_oe | output | 1 | Bus output enable |
| dev_din | input | 16 | Data sampled from the bus |
| dev_ready | input | 1 | Device ready; low stretches the strobe |

## Verification
The bench builds the block with its default parameters: a 20 ns clock period and 8-bit count fields. The reset timing is therefore 4, 15 and 30 clocks, which gives an unconstrained 30-clock cycle with ten recovery clocks. Run-time loads of small values reach the two-clock recovery floor, the zero-pulse case and a mid-cycle reprogramming, all within a few dozen clocks per access. Ready stalls, a stray request in the middle of a cycle and both register groups at both widths are driven against a clock-by-clock behavioural model.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;

  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 3;
  localparam logic [IDX_W-1:0] WIDE_IDX = '0;

  typedef struct packed {
    logic              wr;
    logic              ctl;
    logic              wide;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] wdata;
  } pio_req_t;

  // nanoseconds to clocks, rounded up
  function automatic int unsigned ns_to_clk(int unsigned ns, int unsigned period);
    return (ns + period - 1) / period;
  endfunction

  // one extra setup clock lets the lines settle
  function automatic int unsigned setup_with_ring(int unsigned s);
    return s + 1;
  endfunction

  function automatic int unsigned pulse_floor(int unsigned p);
    return (p == 0) ? 1 : p;
  endfunction

  // at least two recovery clocks after the strobe
  function automatic int unsigned cycle_floor(int unsigned es, int unsigned ep,
                                              int unsigned c);
    int unsigned active;
    active = es + ep;
    return (c < active + 2) ? active + 2 : c;
  endfunction

  function automatic logic is_wide(logic wide, logic ctl, logic [IDX_W-1:0] idx);
    return wide && !ctl && (idx == WIDE_IDX);
  endfunction

  function automatic logic [DATA_W-1:0] lane_fit(logic [DATA_W-1:0] d, logic w);
    return w ? d : {{(DATA_W-BYTE_W){1'b0}}, d[BYTE_W-1:0]};
  endfunction

endpackage

// File: rtl/pio_timing_regs.sv
`timescale 1ns/1ps
module pio_timing_regs #(
  parameter int CNT_W         = 8,
  parameter int TW            = CNT_W + 2,
  parameter int CLK_PERIOD_NS = 20,
  parameter int DEF_SETUP_NS  = 70,
  parameter int DEF_PULSE_NS  = 290,
  parameter int DEF_CYCLE_NS  = 600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_pulse,
  input  logic [CNT_W-1:0] cfg_cycle,
  output logic [TW-1:0]    eff_setup,
  output logic [TW-1:0]    eff_pulse,
  output logic [TW-1:0]    eff_cycle
);
  import pio_pkg::*;

  localparam int DEF_S = int'(ns_to_clk(DEF_SETUP_NS, CLK_PERIOD_NS));
  localparam int DEF_P = int'(ns_to_clk(DEF_PULSE_NS, CLK_PERIOD_NS));
  localparam int DEF_C = int'(ns_to_clk(DEF_CYCLE_NS, CLK_PERIOD_NS));

  logic [CNT_W-1:0] setup_q, pulse_q, cycle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= CNT_W'(DEF_S);
      pulse_q <= CNT_W'(DEF_P);
      cycle_q <= CNT_W'(DEF_C);
    end else if (cfg_wr) begin
      setup_q <= cfg_setup;
      pulse_q <= cfg_pulse;
      cycle_q <= cfg_cycle;
    end
  end

  int unsigned es_i, ep_i, ec_i;

  always_comb begin
    es_i = setup_with_ring(32'(setup_q));
    ep_i = pulse_floor(32'(pulse_q));
    ec_i = cycle_floor(es_i, ep_i, 32'(cycle_q));
  end

  assign eff_setup = TW'(es_i);
  assign eff_pulse = TW'(ep_i);
  assign eff_cycle = TW'(ec_i);

endmodule

// File: rtl/pio_seq.sv
`timescale 1ns/1ps
module pio_seq #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dev_ready,
  input  logic [TW-1:0] eff_setup,
  input  logic [TW-1:0] eff_pulse,
  input  logic [TW-1:0] eff_cycle,
  output logic          busy,
  output logic          cs_on,
  output logic          stb_on,
  output logic          stb_end,
  output logic          last,
  output logic          done
);
  logic [TW-1:0] t_q, setup_q, pulse_q, cycle_q;
  logic [TW-1:0] stb_stop;
  logic          hold;

  assign stb_stop = setup_q + pulse_q;
  assign stb_on   = busy && (t_q >= setup_q) && (t_q < stb_stop);
  assign cs_on    = busy && (t_q != '0) && (t_q <= cycle_q - TW'(2));
  assign last     = busy && (t_q == cycle_q - TW'(1));
  assign hold     = stb_on && !dev_ready;
  assign stb_end  = stb_on && dev_ready && (t_q == stb_stop - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      t_q     <= '0;
      setup_q <= '0;
      pulse_q <= '0;
      cycle_q <= '0;
    end else begin
      done <= last;
      if (start) begin
        busy    <= 1'b1;
        t_q     <= '0;
        setup_q <= eff_setup;
        pulse_q <= eff_pulse;
        cycle_q <= eff_cycle;
      end else if (busy) begin
        if (last) begin
          busy <= 1'b0;
        end else if (!hold) begin
          t_q <= t_q + TW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/pio_bus_map.sv
`timescale 1ns/1ps
module pio_bus_map
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  pio_req_t          req_in,
  input  logic              cs_on,
  input  logic              stb_on,
  input  logic              stb_end,
  input  logic [DATA_W-1:0] dev_din,
  output logic              dev_cs0_n,
  output logic              dev_cs1_n,
  output logic [IDX_W-1:0]  dev_addr,
  output logic              dev_rd_n,
  output logic              dev_wr_n,
  output logic [DATA_W-1:0] dev_dout,
  output logic              dev_oe,
  output logic [DATA_W-1:0] host_rdata
);
  pio_req_t          lreq;
  logic              wide_in;
  logic [DATA_W-1:0] rdata_q;

  assign wide_in = is_wide(req_in.wide, req_in.ctl, req_in.idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lreq    <= '0;
      rdata_q <= '0;
    end else begin
      if (start) begin
        lreq.wr    <= req_in.wr;
        lreq.ctl   <= req_in.ctl;
        lreq.idx   <= req_in.idx;
        lreq.wide  <= wide_in;
        lreq.wdata <= lane_fit(req_in.wdata, wide_in);
      end
      if (stb_end && !lreq.wr) begin
        rdata_q <= lane_fit(dev_din, lreq.wide);
      end
    end
  end

  assign dev_cs0_n  = !(cs_on && !lreq.ctl);
  assign dev_cs1_n  = !(cs_on &&  lreq.ctl);
  assign dev_rd_n   = !(stb_on && !lreq.wr);
  assign dev_wr_n   = !(stb_on &&  lreq.wr);
  assign dev_oe     = cs_on && lreq.wr;
  assign dev_dout   = lreq.wdata;
  assign dev_addr   = lreq.idx;
  assign host_rdata = rdata_q;

endmodule

// File: rtl/pio_cycle_gen.sv
`timescale 1ns/1ps
module pio_cycle_gen #(
  parameter int CNT_W         = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int DEF_SETUP_NS  = 70,
  parameter int DEF_PULSE_NS  = 290,
  parameter int DEF_CYCLE_NS  = 600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_pulse,
  input  logic [CNT_W-1:0] cfg_cycle,
  input  logic             host_req,
  input  logic             host_wr,
  input  logic             host_ctl,
  input  logic             host_wide,
  input  logic [2:0]       host_idx,
  input  logic [15:0]      host_wdata,
  output logic [15:0]      host_rdata,
  output logic             host_done,
  output logic             dev_cs0_n,
  output logic             dev_cs1_n,
  output logic [2:0]       dev_addr,
  output logic             dev_rd_n,
  output logic             dev_wr_n,
  output logic [15:0]      dev_dout,
  output logic             dev_oe,
  input  logic [15:0]      dev_din,
  input  logic             dev_ready
);
  import pio_pkg::*;

  localparam int TW = CNT_W + 2;

  logic [TW-1:0] eff_setup, eff_pulse, eff_cycle;
  logic          cyc_busy, cyc_cs_on, cyc_stb_on, cyc_stb_end, cyc_last;
  logic          req_accept;
  pio_req_t      req_in;

  assign req_accept   = host_req && !cyc_busy;
  assign req_in.wr    = host_wr;
  assign req_in.ctl   = host_ctl;
  assign req_in.wide  = host_wide;
  assign req_in.idx   = host_idx;
  assign req_in.wdata = host_wdata;

  pio_timing_regs #(
    .CNT_W(CNT_W), .TW(TW), .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .DEF_SETUP_NS(DEF_SETUP_NS), .DEF_PULSE_NS(DEF_PULSE_NS),
    .DEF_CYCLE_NS(DEF_CYCLE_NS)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
    .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_cycle(cfg_cycle),
    .eff_setup(eff_setup), .eff_pulse(eff_pulse), .eff_cycle(eff_cycle)
  );

  pio_seq #(.TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(req_accept), .dev_ready(dev_ready),
    .eff_setup(eff_setup), .eff_pulse(eff_pulse), .eff_cycle(eff_cycle),
    .busy(cyc_busy), .cs_on(cyc_cs_on), .stb_on(cyc_stb_on),
    .stb_end(cyc_stb_end), .last(cyc_last), .done(host_done)
  );

  pio_bus_map u_map (
    .clk(clk), .rst_n(rst_n), .start(req_accept), .req_in(req_in),
    .cs_on(cyc_cs_on), .stb_on(cyc_stb_on), .stb_end(cyc_stb_end),
    .dev_din(dev_din), .dev_cs0_n(dev_cs0_n), .dev_cs1_n(dev_cs1_n),
    .dev_addr(dev_addr), .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n),
    .dev_dout(dev_dout), .dev_oe(dev_oe), .host_rdata(host_rdata)
  );

endmodule

// File: rtl/pio_cycle_gen_chk.sv
`timescale 1ns/1ps
module pio_cycle_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dev_cs0_n,
  input logic       dev_cs1_n,
  input logic       dev_rd_n,
  input logic       dev_wr_n,
  input logic       dev_oe,
  input logic       dev_ready,
  input logic       host_done,
  input logic       cyc_busy,
  input logic       cyc_last,
  input logic [2:0] dev_addr
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_busy |-> (dev_cs0_n && dev_cs1_n && dev_rd_n && dev_wr_n && !dev_oe)); // R1

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dev_rd_n && !dev_wr_n)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done); // R3

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_last |=> host_done); // R3

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!dev_cs0_n, !dev_cs1_n})); // R4

  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_rd_n || !dev_wr_n) |-> (!dev_cs0_n || !dev_cs1_n)); // R4

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_busy && !cyc_last) |=> $stable(dev_addr)); // R4

  AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    dev_oe |-> (dev_rd_n && (!dev_cs0_n || !dev_cs1_n))); // R5

  AST_READY_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((!dev_rd_n || !dev_wr_n) && !dev_ready) |=> (!dev_rd_n || !dev_wr_n)); // R8

endmodule

bind pio_cycle_gen pio_cycle_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dev_cs0_n(dev_cs0_n), .dev_cs1_n(dev_cs1_n),
  .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .dev_oe(dev_oe),
  .dev_ready(dev_ready), .host_done(host_done), .cyc_busy(cyc_busy),
  .cyc_last(cyc_last), .dev_addr(dev_addr)
);

// File: tb/pio_cycle_gen_tb.sv
`timescale 1ns/1ps
module pio_cycle_gen_tb;
  localparam int PER = 20;

  logic        clk = 0, rst_n = 0;
  logic        cfg_wr = 0;
  logic [7:0]  cfg_setup = 0, cfg_pulse = 0, cfg_cycle = 0;
  logic        host_req = 0, host_wr = 0, host_ctl = 0, host_wide = 0;
  logic [2:0]  host_idx = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic        host_done;
  logic        dev_cs0_n, dev_cs1_n, dev_rd_n, dev_wr_n, dev_oe;
  logic [2:0]  dev_addr;
  logic [15:0] dev_dout, dev_din = 0;
  logic        dev_ready = 1;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  pio_cycle_gen u_dut (.*);

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  int m_s, m_p, m_c, m_es, m_ep, m_ec, m_t;
  bit m_busy, m_done, m_wr, m_ctl, m_w16;
  logic [2:0]  m_idx;
  logic [15:0] m_wdata, m_rdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_t = 0; m_rdata = 0; m_wr = 0; m_ctl = 0;
      m_idx = 0; m_wdata = 0; m_w16 = 0;
      m_s = (70 + PER - 1) / PER; m_p = (290 + PER - 1) / PER;
      m_c = (600 + PER - 1) / PER;
    end else begin
      m_done = 0;
      if (m_busy) begin
        bit in_stb;
        in_stb = (m_t >= m_es) && (m_t < m_es + m_ep);
        if (m_t == m_ec - 1) begin
          m_busy = 0; m_done = 1;
        end else if (!(in_stb && !dev_ready)) begin
          if (in_stb && m_t == m_es + m_ep - 1 && !m_wr)
            m_rdata = m_w16 ? dev_din : (dev_din & 16'h00ff);
          m_t++;
        end
      end else if (host_req) begin
        m_busy = 1; m_t = 0;
        m_es = m_s + 1;
        m_ep = (m_p == 0) ? 1 : m_p;
        m_ec = (m_c - (m_es + m_ep) < 2) ? m_es + m_ep + 2 : m_c;
        m_wr = host_wr; m_ctl = host_ctl; m_idx = host_idx;
        m_w16 = host_wide && !host_ctl && (host_idx == 3'd0);
        m_wdata = m_w16 ? host_wdata : (host_wdata & 16'h00ff);
      end
      if (cfg_wr) begin
        m_s = int'(cfg_setup); m_p = int'(cfg_pulse); m_c = int'(cfg_cycle);
      end
    end
  end

  always @(negedge clk) begin
    bit stb, csa;
    stb = m_busy && (m_t >= m_es) && (m_t < m_es + m_ep);
    csa = m_busy && (m_t >= 1) && (m_t <= m_ec - 2);
    chk("R4", "cs0_n", int'(dev_cs0_n), int'(!(csa && !m_ctl)));
    chk("R4", "cs1_n", int'(dev_cs1_n), int'(!(csa && m_ctl)));
    chk("R2", "rd_n", int'(dev_rd_n), int'(!(stb && !m_wr)));
    chk("R5", "wr_n", int'(dev_wr_n), int'(!(stb && m_wr)));
    chk("R5", "oe", int'(dev_oe), int'(csa && m_wr));
    chk("R3", "done", int'(host_done), int'(m_done));
    if (m_busy) chk("R4", "addr", int'(dev_addr), int'(m_idx));
    if (csa && m_wr) chk("R6", "dout", int'(dev_dout), int'(m_wdata));
    if (m_done && !m_wr) chk("R7", "rdata", int'(host_rdata), int'(m_rdata));
  end

  function automatic int exp_len(int s, int p, int c);
    int a;
    a = s + 1 + ((p == 0) ? 1 : p);
    return (c - a < 2) ? a + 2 : c;
  endfunction

  logic [7:0] nxt_s = 0, nxt_p = 0, nxt_c = 0;

  // one access; returns clocks to done, clock of first strobe, strobe length
  task automatic do_access(input bit wr, input bit ctl, input bit wide,
                           input logic [2:0] idx, input logic [15:0] wd,
                           input int stalls, input int rep_at, input int cfg_at,
                           output int tot, output int first_stb, output int stb_len);
    int cnt = 0;
    int left = stalls;
    bit seen = 0;
    tot = -1; first_stb = -1; stb_len = 0;
    @(negedge clk);
    host_wr = wr; host_ctl = ctl; host_wide = wide; host_idx = idx;
    host_wdata = wd; host_req = 1;
    while (!seen && cnt < 2000) begin
      @(negedge clk);
      cnt++;
      if (!dev_rd_n || !dev_wr_n) begin
        if (first_stb < 0) first_stb = cnt;
        stb_len++;
      end
      if (host_done) begin seen = 1; tot = cnt; end
      host_req = (cnt == rep_at);
      if (cnt == rep_at) begin host_idx = ~idx; host_wr = ~wr; end
      cfg_wr = (cnt == cfg_at);
      cfg_setup = nxt_s; cfg_pulse = nxt_p; cfg_cycle = nxt_c;
      dev_din = 16'hA55A ^ 16'(cnt * 37);
      if ((!dev_rd_n || !dev_wr_n) && left > 0) begin
        dev_ready = 0; left--;
      end else dev_ready = 1;
    end
    host_req = 0; cfg_wr = 0; dev_ready = 1;
  endtask

  task automatic load_cfg(input int s, input int p, input int c);
    @(negedge clk);
    cfg_setup = 8'(s); cfg_pulse = 8'(p); cfg_cycle = 8'(c); cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  initial begin
    int tot, fs, sl, e;
    repeat (3) @(negedge clk);
    chk("R1", "reset cs0_n", int'(dev_cs0_n), 1);
    chk("R1", "reset cs1_n", int'(dev_cs1_n), 1);
    chk("R1", "reset rd_n", int'(dev_rd_n), 1);
    chk("R1", "reset wr_n", int'(dev_wr_n), 1);
    chk("R1", "reset oe", int'(dev_oe), 0);
    chk("R1", "reset done", int'(host_done), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // reset-default timing, 8-bit write on wide request to a non-data index
    do_access(1, 0, 1, 3'd3, 16'hBEEF, 0, 0, 0, tot, fs, sl);
    e = exp_len(4, 15, 30);
    chk("R10", "default cycle", tot, e + 1);
    chk("R2", "default setup", fs, 4 + 2);
    chk("R2", "default pulse", sl, 15);

    // 16-bit read of the data register
    do_access(0, 0, 1, 3'd0, 16'h0, 0, 0, 0, tot, fs, sl);
    chk("R5", "read cycle same as write", tot, e + 1);

    // recovery floor, control group, wide ignored
    load_cfg(1, 2, 3);
    do_access(0, 1, 1, 3'd6, 16'h0, 0, 0, 0, tot, fs, sl);
    chk("R3", "floor cycle", tot, exp_len(1, 2, 3) + 1);
    chk("R2", "floor setup", fs, 3);
    chk("R6", "ctl read upper byte", int'(host_rdata[15:8]), 0);

    // no floor, 16-bit write
    load_cfg(2, 3, 12);
    do_access(1, 0, 1, 3'd0, 16'hC0DE, 0, 0, 0, tot, fs, sl);
    chk("R3", "long cycle", tot, 13);
    chk("R5", "write pulse", sl, 3);

    // ready stalls stretch the strobe
    do_access(0, 0, 0, 3'd7, 16'h0, 3, 0, 0, tot, fs, sl);
    chk("R8", "stalled pulse", sl, 3 + 3);
    chk("R8", "stalled cycle", tot, 12 + 3 + 1);

    // stray request during a cycle
    do_access(1, 1, 0, 3'd6, 16'h1234, 0, 3, 0, tot, fs, sl);
    chk("R9", "cycle with stray req", tot, 13);
    repeat (3) @(negedge clk);
    chk("R9", "idle after stray cs0_n", int'(dev_cs0_n), 1);
    chk("R9", "idle after stray cs1_n", int'(dev_cs1_n), 1);

    // reprogram in the middle of a cycle: zero pulse and setup
    nxt_s = 0; nxt_p = 0; nxt_c = 0;
    do_access(0, 0, 0, 3'd2, 16'h0, 0, 0, 4, tot, fs, sl);
    chk("R10", "running cycle keeps timing", tot, 13);
    do_access(0, 0, 0, 3'd1, 16'h0, 0, 0, 0, tot, fs, sl);
    chk("R10", "new timing applied", tot, exp_len(0, 0, 0) + 1);
    chk("R2", "zero pulse floor", sl, 1);
    chk("R2", "zero setup", fs, 2);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * PER);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule